// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port

This block controls one general-purpose port of eight pins. Every pin has its own mode register. The mode register turns the input path on or off, asks the pad for a pull-up, turns the output driver on, chooses between a push-pull driver and an emulated open-drain driver, and picks the pin's function. The function is either the plain port or one of seven alternate peripheral functions. A single output-data register holds the drive levels for the plain port function. A read-only input-data register returns the synchronized pin levels of the pins whose input is enabled.

On the pad side, each pin presents an output value, an output enable and a pull-up request. Open-drain behaviour is produced with the enable line alone. The pad is only ever pulled low, and a high level releases it. Each pin receives seven value/enable pairs from peripherals and routes the selected pair onto its pad. The synchronized pin input also goes back to peripherals such as interrupt or timer inputs, and it is forced low unless that pin's input is enabled.

Software reaches the block over a simple synchronous register bus. Reads are combinational on the address, and writes land on the next rising clock edge.

Top module: `gpioPortCtrl`

## Requirements
- R1: While reset is asserted and right after it, every mode register and the output-data register read 0, and the padOe, padOut, padPull and periphIn outputs are all 0.
- R2: Register map and readback. Address i (0 to 7) is the mode register of pin i, address 8 is the output-data register and address 9 is the input-data register. Any other address reads 0 and ignores writes. Mode bits are: bit0 input enable, bit1 pull-up enable, bit2 output enable, bit3 open-drain select (1 = open-drain) and bits 7:4 function select. A write is visible in readback after the next rising edge.
- R3: The input-data register returns the synchronized pin level for pins whose input enable is 1, and returns 0 for all other pins.
- R4: periphIn[i] equals the synchronized level of padIn[i] when pin i has input enable set, and is 0 otherwise.
- R5: A change on padIn is not visible after one rising edge and is visible after the second rising edge, both in the input-data register and on periphIn.
- R6: With function select 0 and push-pull selected, padOe equals the output-enable bit and padOut equals the pin's output-data bit.
- R7: With open-drain selected, padOut is 0 and padOe is 1 exactly when the source enable is 1 and the source value is 0.
- R8: Function select k (1 to 7) makes altOut[pin*7 + k-1] the source value and altOe[pin*7 + k-1] the source enable, and the mode register's output-enable bit is ignored.
- R9: Function select codes 8 to 15 behave exactly like code 0.
- R10: padPull[i] equals the pull-up enable bit of pin i.
- R11: A write to address 9 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data, combinational on busAddr |
| padIn | input | 8 | Pin levels from the pads |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| padPull | output | 8 | Pad pull-up requests |
| altOut | input | 56 | Alternate-function output values, seven per pin |
| altOe | input | 56 | Alternate-function output enables, seven per pin |
| periphIn | output | 8 | Gated, synchronized pin inputs for peripherals |

## Verification
The pad outputs and register readback depend on the stored registers through combinational logic only. They are due one rising edge after a write. The input-data register and periphIn are due two rising edges after padIn changes. In every random step the bench drives a write and new pad stimulus at a falling edge and then lets three rising edges pass. It samples everything at the following falling edge, so every result is settled by then. A directed test samples the input path after the first and after the second edge to pin down the exact two-edge latency.

// File: rtl/gpioPkg.sv
package gpioPkg;

  localparam int MODE_W = 8;
  localparam int IDX_W  = 8;

  typedef struct packed {
    logic [3:0] funcSel;
    logic       openDrain;
    logic       outEn;
    logic       pullEn;
    logic       inEn;
  } pinMode_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MODE = 2'd1,
    RD_DOUT = 2'd2,
    RD_DIN  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic             modeWe;
    logic             doutWe;
    rdSel_e           rdSel;
    logic [IDX_W-1:0] pinIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  localparam int DOUT_ADDR = PIN_COUNT;
  localparam int DIN_ADDR  = PIN_COUNT + 1;

  always_comb begin
    strobe        = '0;
    strobe.pinIdx = IDX_W'(busAddr);
    if (int'(busAddr) < PIN_COUNT) begin
      strobe.rdSel  = RD_MODE;
      strobe.modeWe = busWe;
    end else if (int'(busAddr) == DOUT_ADDR) begin
      strobe.rdSel  = RD_DOUT;
      strobe.doutWe = busWe;
    end else if (int'(busAddr) == DIN_ADDR) begin
      strobe.rdSel  = RD_DIN;
    end
  end

  // R11: the input-data address never raises a write strobe
  a_r11_din_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && int'(busAddr) == DIN_ADDR) |-> (!strobe.modeWe && !strobe.doutWe));

  // R2: at most one register file is written per cycle
  a_r2_single_target: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.modeWe && strobe.doutWe));

endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ALT_COUNT = 7
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrlStrobe_t                    strobe,
  input  logic [MODE_W-1:0]              busWdata,
  output logic [MODE_W-1:0]              busRdata,
  input  logic [PIN_COUNT-1:0]           padIn,
  output logic [PIN_COUNT-1:0]           padOut,
  output logic [PIN_COUNT-1:0]           padOe,
  output logic [PIN_COUNT-1:0]           padPull,
  input  logic [PIN_COUNT*ALT_COUNT-1:0] altOut,
  input  logic [PIN_COUNT*ALT_COUNT-1:0] altOe,
  output logic [PIN_COUNT-1:0]           periphIn
);

  pinMode_t               modeQ [PIN_COUNT];
  logic [PIN_COUNT-1:0]   doutQ;
  logic [PIN_COUNT-1:0]   sync1Q;
  logic [PIN_COUNT-1:0]   sync2Q;
  logic [PIN_COUNT-1:0]   dinGated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PIN_COUNT; i++) modeQ[i] <= '0;
      doutQ  <= '0;
      sync1Q <= '0;
      sync2Q <= '0;
    end else begin
      for (int i = 0; i < PIN_COUNT; i++) begin
        if (strobe.modeWe && strobe.pinIdx == IDX_W'(i)) modeQ[i] <= pinMode_t'(busWdata);
      end
      if (strobe.doutWe) doutQ <= busWdata[PIN_COUNT-1:0];
      sync1Q <= padIn;
      sync2Q <= sync1Q;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (strobe.rdSel)
      RD_MODE: begin
        for (int i = 0; i < PIN_COUNT; i++) begin
          if (strobe.pinIdx == IDX_W'(i)) busRdata = modeQ[i];
        end
      end
      RD_DOUT: busRdata = MODE_W'(doutQ);
      RD_DIN:  busRdata = MODE_W'(dinGated);
      default: busRdata = '0;
    endcase
  end

  assign periphIn = dinGated;

  for (genvar g = 0; g < PIN_COUNT; g++) begin : gPin
    logic srcVal;
    logic srcEn;
    int   altIdx;

    assign dinGated[g] = sync2Q[g] & modeQ[g].inEn;

    always_comb begin
      srcVal = doutQ[g];
      srcEn  = modeQ[g].outEn;
      altIdx = g * ALT_COUNT + int'(modeQ[g].funcSel) - 1;
      if (modeQ[g].funcSel != 4'd0 && int'(modeQ[g].funcSel) <= ALT_COUNT) begin
        srcVal = altOut[altIdx];
        srcEn  = altOe[altIdx];
      end
    end

    assign padOut[g]  = modeQ[g].openDrain ? 1'b0 : srcVal;
    assign padOe[g]   = modeQ[g].openDrain ? (srcEn & ~srcVal) : srcEn;
    assign padPull[g] = modeQ[g].pullEn;

    // R7: an open-drain pin never drives a high level
    a_r7_od_low_only: assert property (@(posedge clk) disable iff (!rstN)
      (modeQ[g].openDrain && padOe[g]) |-> !padOut[g]);

    // R4: a pin with input disabled keeps its peripheral input low
    a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
      !modeQ[g].inEn |-> !periphIn[g]);

    // R5: a high peripheral input was high on the pad two edges earlier
    a_r5_sync_depth: assert property (@(posedge clk) disable iff (!rstN)
      periphIn[g] |-> $past(padIn[g], 2));
  end

  // R2: an output-data write lands on the next edge
  a_r2_dout_lands: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.doutWe) |-> (doutQ == $past(busWdata[PIN_COUNT-1:0])));

  // R1: reset leaves all pads released
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |-> (padOe == '0 && padPull == '0));

endmodule

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ALT_COUNT = 7,
  parameter int ADDR_W    = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busWe,
  input  logic [ADDR_W-1:0]              busAddr,
  input  logic [MODE_W-1:0]              busWdata,
  output logic [MODE_W-1:0]              busRdata,
  input  logic [PIN_COUNT-1:0]           padIn,
  output logic [PIN_COUNT-1:0]           padOut,
  output logic [PIN_COUNT-1:0]           padOe,
  output logic [PIN_COUNT-1:0]           padPull,
  input  logic [PIN_COUNT*ALT_COUNT-1:0] altOut,
  input  logic [PIN_COUNT*ALT_COUNT-1:0] altOe,
  output logic [PIN_COUNT-1:0]           periphIn
);

  ctrlStrobe_t strobe;

  gpioCtrl #(
    .PIN_COUNT(PIN_COUNT),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  gpioDatapath #(
    .PIN_COUNT(PIN_COUNT),
    .ALT_COUNT(ALT_COUNT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .padIn   (padIn),
    .padOut  (padOut),
    .padOe   (padOe),
    .padPull (padPull),
    .altOut  (altOut),
    .altOe   (altOe),
    .periphIn(periphIn)
  );

endmodule

// File: tb/gpioPortCtrl_tb.sv
`timescale 1ns/1ps
module gpioPortCtrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut, padOe, padPull, periphIn;
  logic [55:0] altOut = '0;
  logic [55:0] altOe = '0;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  logic [7:0] modeM [8];
  logic [7:0] doutM;

  always #2.5 clk = ~clk;

  gpioPortCtrl u_dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPull(padPull),
    .altOut(altOut), .altOe(altOe), .periphIn(periphIn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expPad(int p);
    logic [3:0] sel;
    logic v, e;
    sel = modeM[p][7:4];
    v = doutM[p];
    e = modeM[p][2];
    if (sel >= 4'd1 && sel <= 4'd7) begin
      v = altOut[p*7 + int'(sel) - 1];
      e = altOe[p*7 + int'(sel) - 1];
    end
    if (modeM[p][3]) return {1'b0, e & ~v};
    return {v, e};
  endfunction

  function automatic string padTag(int p);
    if (modeM[p][7:4] >= 4'd8) return "R9";
    if (modeM[p][7:4] != 4'd0) return "R8";
    if (modeM[p][3]) return "R7";
    return "R6";
  endfunction

  function automatic logic [7:0] inMask();
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = modeM[i][0];
    return m;
  endfunction

  task automatic busWrite(int a, logic [7:0] d);
    busWe = 1'b1;
    busAddr = 4'(a);
    busWdata = d;
    if (a < 8) modeM[a] = d;
    else if (a == 8) doutM = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readAll(string req);
    for (int a = 0; a < 11; a++) begin
      logic [7:0] e;
      busAddr = 4'(a);
      #0.1;
      if (a < 8) e = modeM[a];
      else if (a == 8) e = doutM;
      else if (a == 9) e = padIn & inMask();
      else e = 8'h00;
      chk(req, busRdata, e);
    end
  endtask

  task automatic checkPads();
    for (int p = 0; p < 8; p++) begin
      logic [1:0] ep;
      ep = expPad(p);
      chk(padTag(p), {padOut[p], padOe[p]}, ep);
      chk("R10", padPull[p], modeM[p][1]);
    end
    chk("R4", periphIn, padIn & inMask());
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) modeM[i] = '0;
    doutM = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", {padOe, padOut, padPull, periphIn}, 32'h0);
    readAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", {padOe, padPull}, 16'h0);

    // R5: exact synchronizer latency on pin 0
    busWrite(0, 8'h01);
    repeat (3) @(negedge clk);
    padIn = 8'h01;
    @(negedge clk);
    busAddr = 4'd9; #0.1;
    chk("R5", busRdata[0], 1'b0);
    chk("R5", periphIn[0], 1'b0);
    @(negedge clk);
    busAddr = 4'd9; #0.1;
    chk("R5", busRdata[0], 1'b1);
    chk("R5", periphIn[0], 1'b1);
    // R3: disabled pin reads 0 although its pad is high
    padIn = 8'h03;
    repeat (3) @(negedge clk);
    busAddr = 4'd9; #0.1;
    chk("R3", busRdata, 8'h01);

    // R11: writing the input-data address changes nothing
    busWrite(8, 8'h5A);
    busWrite(9, 8'hFF);
    repeat (2) @(negedge clk);
    readAll("R11");

    // R9: reserved code behaves as plain port, R8 alt ignores outEn
    busWrite(2, 8'hC4);
    busWrite(3, 8'h30);
    altOut[3*7 + 2] = 1'b1;
    altOe[3*7 + 2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", {padOut[2], padOe[2]}, {doutM[2], 1'b1});
    chk("R8", {padOut[3], padOe[3]}, 2'b11);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int a;
      padIn = 8'($urandom);
      altOut = {24'($urandom), 32'($urandom)};
      altOe = {24'($urandom), 32'($urandom)};
      a = int'($urandom % 11);
      busWrite(a, 8'($urandom));
      repeat (2) @(negedge clk);
      checkPads();
      readAll("R2");
      chk("R3", {24'h0, padIn & inMask()}, {24'h0, periphIn});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule